// File: doc/BRIEF.md
# Four-Colour Endpoint Tile Decoder

The block turns one 64-bit compressed colour tile, covering a 4x4 patch of texels, into sixteen 32-bit RGBA texels. The tile holds two 16-bit endpoint colours and a 2-bit palette selector for each texel. From the two endpoints the block builds a four-entry palette. If the first endpoint word is numerically greater than the second, the palette is four opaque colours: the two endpoints and two colours that blend them in thirds. Otherwise the palette is the two endpoints, their midpoint, and one fully transparent entry.

A tile enters through a valid/ready handshake. The block then streams the sixteen texels in raster order, one per accepted output beat, and marks the sixteenth with a last flag. The palette is registered when the tile is accepted. A new tile can be taken in the same cycle as the final texel of the previous one, so a steady stream of tiles produces texels with no gap.

Top module: `tcd_tile_decoder`

## Requirements
- R1: After reset, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: Endpoint word e0 is `tile_i[15:0]` and e1 is `tile_i[31:16]`. Each word is red[15:11], green[10:5], blue[4:0]. A 5-bit field v widens to {v, v[4:2]} and a 6-bit field v widens to {v, v[5:4]}. Selector 0 outputs widened e0 and selector 1 outputs widened e1, both with alpha 255.
- R3: When e0 > e1 (unsigned), selector 2 gives per channel floor((2*E0 + E1)/3) and selector 3 gives floor((E0 + 2*E1)/3), on the widened 8-bit values, with alpha 255.
- R4: When e0 < e1, selector 2 gives per channel floor((E0 + E1)/2) with alpha 255, and selector 3 gives an all-zero texel (R, G, B and A all 0).
- R5: When e0 == e1, the palette follows the R4 rule.
- R6: The selector for texel k (k = 0..15, row-major) is `tile_i[33+2k:32+2k]`. Texels leave in order k = 0, 1, ..., 15.
- R7: `out_last_o` is 1 on texel 15 of each tile and 0 on every other texel.
- R8: `in_ready_o` is 0 while a tile is being emitted, except in the cycle in which texel 15 is taken. With input always valid and output always ready, consecutive tiles stream with no idle cycle.
- R9: While `out_valid_o` is 1 and `out_ready_i` is 0, the texel and `out_last_o` hold their values into the next cycle.
- R10: `out_valid_o` is 1 in the cycle after a tile is accepted.
- R11: `out_rgba_o` packs red in [31:24], green in [23:16], blue in [15:8] and alpha in [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Tile present |
| in_ready_o | output | 1 | Decoder can take a tile |
| tile_i | input | 64 | Compressed tile |
| out_valid_o | output | 1 | Texel present |
| out_ready_i | input | 1 | Consumer takes texel |
| out_rgba_o | output | 32 | Decoded texel, R/G/B/A from high byte to low |
| out_last_o | output | 1 | Marks texel 15 of the tile |

## Verification
The bench builds the block with its default 4x4 tile, the only geometry the packed format allows. This puts every texel position and all four selector codes within reach of each tile. About a hundred and sixty tiles are swept, including the equal-endpoint case, neighbouring endpoint words, and the extreme words 0x0000 and 0xFFFF in both orders, so that both palette modes and the truncation limits of the blend arithmetic are covered. A first run with a consumer that never stalls exposes any bubble between tiles. Pseudo-random stalls and input gaps then test the hold and handshake rules.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  localparam int unsigned EP_W  = 16;
  localparam int unsigned IDX_W = 2;
  localparam int unsigned PAL_N = 1 << IDX_W;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
    logic [7:0] a;
  } rgba_t;

  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  // weight 2:1 toward a, truncated
  function automatic logic [7:0] third_mix(input logic [7:0] a, input logic [7:0] b);
    logic [9:0] s;
    logic [9:0] q;
    s = {1'b0, a, 1'b0} + {2'b00, b};
    q = s / 10'd3;
    return q[7:0];
  endfunction

  function automatic logic [7:0] half_mix(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[8:1];
  endfunction
endpackage

// File: rtl/tcd_endpoint_unpack.sv
module tcd_endpoint_unpack
  import tcd_pkg::*;
(
  input  logic [EP_W-1:0] word_i,
  output rgba_t           color_o
);
  always_comb begin
    color_o.r = widen5(word_i[15:11]);
    color_o.g = widen6(word_i[10:5]);
    color_o.b = widen5(word_i[4:0]);
    color_o.a = 8'hFF;
  end
endmodule

// File: rtl/tcd_palette_gen.sv
module tcd_palette_gen
  import tcd_pkg::*;
(
  input  rgba_t              c0_i,
  input  rgba_t              c1_i,
  input  logic               punch_i,
  output rgba_t [PAL_N-1:0]  pal_o
);
  rgba_t mid_a, mid_b;

  always_comb begin
    if (punch_i) begin
      mid_a.r = half_mix(c0_i.r, c1_i.r);
      mid_a.g = half_mix(c0_i.g, c1_i.g);
      mid_a.b = half_mix(c0_i.b, c1_i.b);
      mid_a.a = 8'hFF;
      mid_b   = '0;
    end else begin
      mid_a.r = third_mix(c0_i.r, c1_i.r);
      mid_a.g = third_mix(c0_i.g, c1_i.g);
      mid_a.b = third_mix(c0_i.b, c1_i.b);
      mid_a.a = 8'hFF;
      mid_b.r = third_mix(c1_i.r, c0_i.r);
      mid_b.g = third_mix(c1_i.g, c0_i.g);
      mid_b.b = third_mix(c1_i.b, c0_i.b);
      mid_b.a = 8'hFF;
    end
  end

  assign pal_o[0] = c0_i;
  assign pal_o[1] = c1_i;
  assign pal_o[2] = mid_a;
  assign pal_o[3] = mid_b;
endmodule

// File: rtl/tcd_texel_seq.sv
module tcd_texel_seq #(
  parameter int unsigned NUM_TEXELS = 16,
  parameter int unsigned IDX_W      = 2,
  localparam int unsigned CNT_W     = $clog2(NUM_TEXELS),
  localparam int unsigned SEL_BITS  = NUM_TEXELS * IDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SEL_BITS-1:0] sel_i,
  output logic                load_o,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [IDX_W-1:0]    sel_o,
  output logic                last_o
);
  logic                busy_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [SEL_BITS-1:0] sel_q;
  logic                take;

  assign take        = busy_q & out_ready_i;
  assign last_o      = busy_q & (cnt_q == CNT_W'(NUM_TEXELS - 1));
  assign in_ready_o  = ~busy_q | (take & last_o);
  assign load_o      = in_valid_i & in_ready_o;
  assign out_valid_o = busy_q;
  assign sel_o       = sel_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sel_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      sel_q  <= sel_i;
    end else if (take) begin
      if (last_o) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
      sel_q <= sel_q >> IDX_W;
    end
  end
endmodule

// File: rtl/tcd_tile_decoder.sv
module tcd_tile_decoder
  import tcd_pkg::*;
#(
  parameter int unsigned TILE_DIM   = 4,
  localparam int unsigned NUM_TEXELS = TILE_DIM * TILE_DIM,
  localparam int unsigned TILE_W     = 2 * EP_W + NUM_TEXELS * IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [TILE_W-1:0] tile_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [31:0]       out_rgba_o,
  output logic              out_last_o
);
  rgba_t              ep [2];
  rgba_t [PAL_N-1:0]  pal_d, pal_q;
  logic               punch;
  logic               load;
  logic [IDX_W-1:0]   sel;

  for (genvar e = 0; e < 2; e++) begin : g_ep
    tcd_endpoint_unpack u_unpack (
      .word_i  (tile_i[e*EP_W +: EP_W]),
      .color_o (ep[e])
    );
  end

  // equal endpoints fall into the transparent-entry palette
  assign punch = tile_i[EP_W-1:0] <= tile_i[2*EP_W-1:EP_W];

  tcd_palette_gen u_pal (
    .c0_i    (ep[0]),
    .c1_i    (ep[1]),
    .punch_i (punch),
    .pal_o   (pal_d)
  );

  tcd_texel_seq #(
    .NUM_TEXELS (NUM_TEXELS),
    .IDX_W      (IDX_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .sel_i       (tile_i[TILE_W-1:2*EP_W]),
    .load_o      (load),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .sel_o       (sel),
    .last_o      (out_last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pal_q <= '0;
    else if (load) pal_q <= pal_d;
  end

  assign out_rgba_o = pal_q[sel];
endmodule

// File: rtl/tcd_tile_decoder_chk.sv
module tcd_tile_decoder_chk #(
  parameter int unsigned NUM_TEXELS = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_rgba_o,
  input logic        out_last_o
);
  localparam int unsigned CW = $clog2(NUM_TEXELS);
  logic [CW-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_q <= '0;
    else if (out_valid_o && out_ready_i) beat_q <= out_last_o ? '0 : beat_q + 1'b1;
  end

  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_rgba_o) && $stable(out_last_o));

  p_ready_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !(out_ready_i && out_last_o) |-> !in_ready_o);

  p_first_after_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  p_last_position_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_last_o == (beat_q == CW'(NUM_TEXELS - 1))));

  p_alpha_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_rgba_o[7:0] == 8'hFF) || (out_rgba_o == 32'h0));
endmodule

bind tcd_tile_decoder tcd_tile_decoder_chk #(.NUM_TEXELS(NUM_TEXELS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_rgba_o  (out_rgba_o),
  .out_last_o  (out_last_o)
);

// File: tb/tcd_tile_decoder_tb_top.sv
module tcd_tile_decoder_tb_top;
  localparam int NT   = 160;
  localparam int NT_A = 40;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [63:0] tile_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [31:0] out_rgba_o;
  logic        out_last_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  tcd_tile_decoder dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .tile_i(tile_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_rgba_o(out_rgba_o), .out_last_o(out_last_o)
  );

  logic [63:0] tiles [NT];

  function automatic logic [7:0] w5(input logic [4:0] v);
    return 8'((int'(v) << 3) | (int'(v) >> 2));
  endfunction
  function automatic logic [7:0] w6(input logic [5:0] v);
    return 8'((int'(v) << 2) | (int'(v) >> 4));
  endfunction

  function automatic logic [31:0] exp_texel(input logic [63:0] t, input int k);
    int c0, c1, s;
    int e0 [3];
    int e1 [3];
    int o [3];
    int a;
    c0 = int'(t[15:0]);
    c1 = int'(t[31:16]);
    e0[0] = int'(w5(t[15:11]));  e0[1] = int'(w6(t[10:5]));  e0[2] = int'(w5(t[4:0]));
    e1[0] = int'(w5(t[31:27]));  e1[1] = int'(w6(t[26:21])); e1[2] = int'(w5(t[20:16]));
    s = int'(t[32 + 2*k +: 2]);
    a = 255;
    for (int c = 0; c < 3; c++) begin
      case (s)
        0: o[c] = e0[c];
        1: o[c] = e1[c];
        2: o[c] = (c0 > c1) ? (2*e0[c] + e1[c]) / 3 : (e0[c] + e1[c]) / 2;
        default: o[c] = (c0 > c1) ? (e0[c] + 2*e1[c]) / 3 : 0;
      endcase
    end
    if (s == 3 && c0 <= c1) a = 0;
    return {8'(o[0]), 8'(o[1]), 8'(o[2]), 8'(a)};
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    logic [31:0] r;
    int tile_ptr, out_tile, out_k, cyc, bubbles, ready_viol, lat_viol;
    bit started, acc_prev, stall_prev;
    logic [31:0] held_rgba;
    logic held_last;

    r = 32'h1234_5678;
    // R5 equal, R3/R4 extremes and adjacent words; selectors cycle 0,1,2,3
    tiles[0] = {32'hE4E4_E4E4, 16'h7BEF, 16'h7BEF};
    tiles[1] = {32'hE4E4_E4E4, 16'h0000, 16'hFFFF};
    tiles[2] = {32'hE4E4_E4E4, 16'hFFFF, 16'h0000};
    tiles[3] = {32'h1B1B_1B1B, 16'h8001, 16'h8000};
    tiles[4] = {32'h1B1B_1B1B, 16'h8000, 16'h8001};
    tiles[5] = {32'hFFFF_FFFF, 16'h0000, 16'h0000};
    for (int i = 6; i < NT; i++) begin
      logic [31:0] a, b;
      r = xs(r); a = r;
      r = xs(r); b = r;
      tiles[i] = {b, a};
    end

    // R1 reset state
    #5;
    check("R1 out_valid", {63'b0, out_valid_o}, 64'd0);
    check("R1 in_ready",  {63'b0, in_ready_o},  64'd1);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    tile_ptr = 0; out_tile = 0; out_k = 0; cyc = 0;
    bubbles = 0; ready_viol = 0; lat_viol = 0;
    started = 0; acc_prev = 0; stall_prev = 0;
    held_rgba = '0; held_last = 0;

    while (out_tile < NT) begin
      @(negedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        check("watchdog", 64'd0, 64'd1);
        break;
      end
      r = xs(r);
      out_ready_i = (out_tile < NT_A) ? 1'b1 : r[3] | r[7];
      in_valid_i  = (tile_ptr < NT) && ((tile_ptr < NT_A) || r[11] || r[12]);
      tile_i      = (tile_ptr < NT) ? tiles[tile_ptr] : 64'd0;
      #1;
      // R9 hold after stall
      if (stall_prev) begin
        check("R9 rgba hold", {32'b0, out_rgba_o}, {32'b0, held_rgba});
        check("R9 last hold", {63'b0, out_last_o}, {63'b0, held_last});
      end
      // R10 latency
      if (acc_prev && !out_valid_o) lat_viol++;
      // R8 bubble-free in stall-free phase
      if (started && out_tile < NT_A && !out_valid_o) bubbles++;
      if (out_valid_o && !(out_ready_i && out_k == 15) && in_ready_o) ready_viol++;
      acc_prev = in_valid_i && in_ready_o;
      if (acc_prev) begin
        tile_ptr++;
        started = 1;
      end
      stall_prev = out_valid_o && !out_ready_i;
      held_rgba = out_rgba_o;
      held_last = out_last_o;
      if (out_valid_o && out_ready_i) begin
        // R2 R3 R4 R5 R6 R11 texel value
        check("R2/R3/R4/R5/R6/R11 texel", {32'b0, out_rgba_o},
              {32'b0, exp_texel(tiles[out_tile], out_k)});
        check("R7 last flag", {63'b0, out_last_o}, {63'b0, out_k == 15});
        if (out_k == 15) begin
          out_k = 0;
          out_tile++;
        end else out_k++;
      end
    end
    check("R8 bubbles between tiles", 64'(bubbles), 64'd0);
    check("R8 ready while emitting", 64'(ready_viol), 64'd0);
    check("R10 valid after accept", 64'(lat_viol), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule